// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register storage of a processor core whose visible register set depends on a 5-bit operating mode. Software always addresses sixteen logical registers, index 0 to 15. The current mode decides which physical storage each index reaches. The five exception modes each keep private copies of some registers, so an exception handler can use its own stack pointer (index 13) and return-link register (index 14) without saving the interrupted code's copies first. The fast-interrupt mode also keeps private copies of indexes 8 to 12.

The block has two combinational read ports and one write port for general registers. Register 15 is plain storage here. There is also one saved-status register for each exception mode. It is reached through a dedicated read output and a write strobe, and the current mode selects which one is used. Decode, the ALU and program-counter sequencing sit outside the block. Those parts present the mode, the indexes and the write data on every cycle.

The storage is 31 general words (16 shared, 7 fast-interrupt copies, and 2 copies for each of four other exception modes) plus 5 saved-status words. All of them are cleared by an active-low reset.

Top module: `bankreg_file`

## Requirements
- R1: After reset, every register and every saved-status register reads as zero.
- R2: In user mode (mode 5'b10000), logical indexes 0 to 15 reach 16 shared registers. A value written to an index reads back from that index on the next cycle.
- R3: System mode (5'b11111) uses exactly the user register set. A write made in one of these two modes is visible in the other.
- R4: Fast-interrupt mode (5'b10001) has private copies of indexes 8 to 14. Writes there leave the user copies unchanged, and its indexes 0 to 7 and 15 reach the shared registers.
- R5: Interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have private copies of indexes 13 and 14 only. A write in one of these modes affects neither the other modes' copies nor the user copies.
- R6: Each of the five exception modes has its own saved-status register. A saved-status write in that mode reads back on the next cycle, and it leaves the other modes' saved-status values unchanged.
- R7: In user and system mode, the saved-status output reads zero and a saved-status write has no effect on any saved-status register.
- R8: Any mode encoding not listed in R2 to R5 maps registers exactly as user mode does and has no saved-status register.
- R9: When a read and a write hit the same physical register in the same cycle, the read returns the old value. The new value is returned from the next cycle onward.
- R10: The two read ports are independent. They return different registers in the same cycle, and they return the same value when given the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all storage |
| mode_i | input | 5 | Current operating mode |
| rda_idx_i | input | 4 | Logical index, operand A read port |
| rda_data_o | output | 32 | Operand A read data |
| rdb_idx_i | input | 4 | Logical index, operand B read port |
| rdb_data_o | output | 32 | Operand B read data |
| wr_en_i | input | 1 | General register write strobe |
| wr_idx_i | input | 4 | Logical index to write |
| wr_data_i | input | 32 | General register write data |
| sav_wr_en_i | input | 1 | Saved-status write strobe |
| sav_wr_data_i | input | 32 | Saved-status write data |
| sav_rd_data_o | output | 32 | Current mode's saved-status value, zero when the mode has none |

## Verification
The bench walks the register file through directed patterns. First it fills all sixteen indexes in user mode. It then reads them back from every other mode, which shows which indexes are banked and which are shared in each mode. Next it writes indexes 13 and 14 in each exception mode with a different value and reads them across modes. This catches a mapper that sends two modes to the same bank, or any bank to the user copy. Saved-status writes are made in every mode, including user, system and two unlisted encodings, which separates real banks from ignored writes. A final phase issues random modes, indexes and writes, often with a read index equal to the write index in the same cycle. This exercises the old-value-on-collision rule under a mix of modes.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    localparam int IDX_W     = 4;
    localparam int MODE_W    = 5;
    localparam int SHARED_N  = 16;
    localparam int FIQ_LO    = 8;
    localparam int FIQ_N     = 7;
    localparam int PRIV_LO   = 13;
    localparam int PRIV_N    = 2;
    localparam int PRIV_BK_N = 4;
    localparam int PHYS_N    = SHARED_N + FIQ_N + PRIV_N * PRIV_BK_N;
    localparam int PIDX_W    = $clog2(PHYS_N);
    localparam int SAVED_N   = 1 + PRIV_BK_N;
    localparam int SIDX_W    = $clog2(SAVED_N);

    localparam logic [MODE_W-1:0] MD_USER = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FIQ  = 5'b10001;
    localparam logic [MODE_W-1:0] MD_IRQ  = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SVC  = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABT  = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UND  = 5'b11011;
    localparam logic [MODE_W-1:0] MD_SYS  = 5'b11111;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

endpackage

// File: rtl/bankreg_mode_dec.sv
module bankreg_mode_dec
    import bankreg_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o,
    output logic              sav_vld_o,
    output logic [SIDX_W-1:0] sav_idx_o
);

    always_comb begin
        bank_o = BK_USR;
        unique case (mode_i)
            MD_FIQ:  bank_o = BK_FIQ;
            MD_IRQ:  bank_o = BK_IRQ;
            MD_SVC:  bank_o = BK_SVC;
            MD_ABT:  bank_o = BK_ABT;
            MD_UND:  bank_o = BK_UND;
            default: bank_o = BK_USR;
        endcase
    end

    // Saved-status slot: one per exception bank, none for the user bank.
    always_comb begin
        sav_vld_o = (bank_o != BK_USR);
        sav_idx_o = '0;
        if (sav_vld_o) begin
            sav_idx_o = SIDX_W'(int'(bank_o) - 1);
        end
    end

endmodule

// File: rtl/bankreg_idx_map.sv
module bankreg_idx_map
    import bankreg_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  bank_e             bank_i,
    output logic [PIDX_W-1:0] phys_o
);

    localparam logic [IDX_W-1:0] FIQ_FIRST  = IDX_W'(FIQ_LO);
    localparam logic [IDX_W-1:0] FIQ_LAST   = IDX_W'(FIQ_LO + FIQ_N - 1);
    localparam logic [IDX_W-1:0] PRIV_FIRST = IDX_W'(PRIV_LO);
    localparam logic [IDX_W-1:0] PRIV_LAST  = IDX_W'(PRIV_LO + PRIV_N - 1);
    localparam int FIQ_BASE  = SHARED_N;
    localparam int PRIV_BASE = SHARED_N + FIQ_N;

    logic in_fiq_rng;
    logic in_priv_rng;
    logic priv_bank;

    always_comb begin
        in_fiq_rng  = (idx_i >= FIQ_FIRST) && (idx_i <= FIQ_LAST);
        in_priv_rng = (idx_i >= PRIV_FIRST) && (idx_i <= PRIV_LAST);
        priv_bank   = (bank_i == BK_IRQ) || (bank_i == BK_SVC) ||
                      (bank_i == BK_ABT) || (bank_i == BK_UND);
        phys_o = PIDX_W'(idx_i);
        if ((bank_i == BK_FIQ) && in_fiq_rng) begin
            phys_o = PIDX_W'(FIQ_BASE + int'(idx_i) - FIQ_LO);
        end else if (priv_bank && in_priv_rng) begin
            phys_o = PIDX_W'(PRIV_BASE
                             + PRIV_N * (int'(bank_i) - int'(BK_IRQ))
                             + int'(idx_i) - PRIV_LO);
        end
    end

endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RD_N   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [RD_N-1:0][PIDX_W-1:0]    rd_phys_i,
    output logic [RD_N-1:0][DATA_W-1:0]    rd_data_o,
    input  logic                           wr_en_i,
    input  logic [PIDX_W-1:0]              wr_phys_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    input  logic [SIDX_W-1:0]              sav_idx_i,
    input  logic                           sav_wr_en_i,
    input  logic [DATA_W-1:0]              sav_wr_data_i,
    output logic [DATA_W-1:0]              sav_rd_data_o
);

    typedef struct packed {
        logic [PHYS_N-1:0][DATA_W-1:0]  gpr;
        logic [SAVED_N-1:0][DATA_W-1:0] sav;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.gpr[wr_phys_i] = wr_data_i;
        end
        if (sav_wr_en_i) begin
            st_d.sav[sav_idx_i] = sav_wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Reads come from the registered state, so a colliding write shows next cycle.
    for (genvar p = 0; p < RD_N; p++) begin : g_rd
        assign rd_data_o[p] = st_q.gpr[rd_phys_i[p]];
    end

    assign sav_rd_data_o = st_q.sav[sav_idx_i];

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic [3:0]        rda_idx_i,
    output logic [DATA_W-1:0] rda_data_o,
    input  logic [3:0]        rdb_idx_i,
    output logic [DATA_W-1:0] rdb_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              sav_wr_en_i,
    input  logic [DATA_W-1:0] sav_wr_data_i,
    output logic [DATA_W-1:0] sav_rd_data_o
);

    localparam int RD_N  = 2;
    localparam int MAP_N = RD_N + 1;

    bank_e                          bank;
    logic                           sav_vld;
    logic [SIDX_W-1:0]              sav_idx;
    logic [MAP_N-1:0][IDX_W-1:0]    map_idx;
    logic [MAP_N-1:0][PIDX_W-1:0]   map_phys;
    logic [RD_N-1:0][DATA_W-1:0]    rd_data;
    logic [DATA_W-1:0]              sav_raw;

    bankreg_mode_dec u_dec (
        .mode_i    (mode_i),
        .bank_o    (bank),
        .sav_vld_o (sav_vld),
        .sav_idx_o (sav_idx)
    );

    assign map_idx[0] = rda_idx_i;
    assign map_idx[1] = rdb_idx_i;
    assign map_idx[2] = wr_idx_i;

    for (genvar m = 0; m < MAP_N; m++) begin : g_map
        bankreg_idx_map u_map (
            .idx_i  (map_idx[m]),
            .bank_i (bank),
            .phys_o (map_phys[m])
        );
    end

    bankreg_store #(
        .DATA_W (DATA_W),
        .RD_N   (RD_N)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_phys_i     (map_phys[RD_N-1:0]),
        .rd_data_o     (rd_data),
        .wr_en_i       (wr_en_i),
        .wr_phys_i     (map_phys[RD_N]),
        .wr_data_i     (wr_data_i),
        .sav_idx_i     (sav_idx),
        .sav_wr_en_i   (sav_wr_en_i && sav_vld),
        .sav_wr_data_i (sav_wr_data_i),
        .sav_rd_data_o (sav_raw)
    );

    assign rda_data_o    = rd_data[0];
    assign rdb_data_o    = rd_data[1];
    assign sav_rd_data_o = sav_vld ? sav_raw : '0;

endmodule

// File: rtl/bankreg_file_chk.sv
module bankreg_file_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode_i,
    input logic [3:0]        rda_idx_i,
    input logic [DATA_W-1:0] rda_data_o,
    input logic [3:0]        rdb_idx_i,
    input logic [DATA_W-1:0] rdb_data_o,
    input logic              wr_en_i,
    input logic [3:0]        wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              sav_wr_en_i,
    input logic [DATA_W-1:0] sav_wr_data_i,
    input logic [DATA_W-1:0] sav_rd_data_o
);

    logic exc_mode;
    assign exc_mode = (mode_i == 5'b10001) || (mode_i == 5'b10010) ||
                      (mode_i == 5'b10011) || (mode_i == 5'b10111) ||
                      (mode_i == 5'b11011);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rda_data_o == '0 && rdb_data_o == '0 && sav_rd_data_o == '0)); // R1

    AST_NO_SAVED_OUTSIDE_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_mode |-> (sav_rd_data_o == '0)); // R7

    AST_WRITE_SEEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == rda_idx_i) ##1 ($stable(mode_i) && $stable(rda_idx_i))
        |-> (rda_data_o == $past(wr_data_i))); // R9

    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rda_idx_i == rdb_idx_i) |-> (rda_data_o == rdb_data_o)); // R10

    AST_SAVED_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sav_wr_en_i && exc_mode) ##1 $stable(mode_i)
        |-> (sav_rd_data_o == $past(sav_wr_data_i))); // R6

endmodule

bind bankreg_file bankreg_file_chk #(.DATA_W(DATA_W)) chk (.*);

// File: tb/bankreg_file_test.sv
`timescale 1ns/1ps
module bankreg_file_test;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    mode_i = 5'b10000;
    logic [3:0]    rda_idx_i = '0;
    logic [3:0]    rdb_idx_i = '0;
    logic [DW-1:0] rda_data_o, rdb_data_o, sav_rd_data_o;
    logic          wr_en_i = 1'b0;
    logic [3:0]    wr_idx_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic          sav_wr_en_i = 1'b0;
    logic [DW-1:0] sav_wr_data_i = '0;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    logic [DW-1:0] ref_gpr [string];
    logic [DW-1:0] ref_sav [string];

    always #2 clk = ~clk;

    bankreg_file #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .rda_idx_i(rda_idx_i), .rda_data_o(rda_data_o),
        .rdb_idx_i(rdb_idx_i), .rdb_data_o(rdb_data_o),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .sav_wr_en_i(sav_wr_en_i), .sav_wr_data_i(sav_wr_data_i),
        .sav_rd_data_o(sav_rd_data_o)
    );

    // Which bank owns a logical index in a given mode, by the requirement text.
    function automatic string owner(logic [4:0] m, int idx);
        string nm;
        nm = "";
        case (m)
            5'b10001: nm = "fiq";
            5'b10010: nm = "irq";
            5'b10011: nm = "svc";
            5'b10111: nm = "abt";
            5'b11011: nm = "und";
            default:  nm = "";
        endcase
        if (nm == "fiq" && idx >= 8 && idx <= 14) return "fiq";
        if (nm != "" && nm != "fiq" && (idx == 13 || idx == 14)) return nm;
        return "usr";
    endfunction

    function automatic string sav_owner(logic [4:0] m);
        case (m)
            5'b10001: return "fiq";
            5'b10010: return "irq";
            5'b10011: return "svc";
            5'b10111: return "abt";
            5'b11011: return "und";
            default:  return "";
        endcase
    endfunction

    function automatic logic [DW-1:0] ref_rd(logic [4:0] m, int idx);
        string k;
        k = $sformatf("%s_%0d", owner(m, idx), idx);
        if (ref_gpr.exists(k)) return ref_gpr[k];
        return '0;
    endfunction

    function automatic logic [DW-1:0] ref_srd(logic [4:0] m);
        string k;
        k = sav_owner(m);
        if (k == "") return '0;
        if (ref_sav.exists(k)) return ref_sav[k];
        return '0;
    endfunction

    task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, compare before the rising edge, update model at the edge.
    task automatic step(string tag, logic [4:0] m, int ra, int rb,
                        bit we, int wi, logic [DW-1:0] wd,
                        bit swe, logic [DW-1:0] swd);
        @(negedge clk);
        mode_i = m; rda_idx_i = 4'(ra); rdb_idx_i = 4'(rb);
        wr_en_i = we; wr_idx_i = 4'(wi); wr_data_i = wd;
        sav_wr_en_i = swe; sav_wr_data_i = swd;
        #1;
        check(tag, $sformatf("mode=%b porta idx=%0d", m, ra), rda_data_o, ref_rd(m, ra));
        check(tag, $sformatf("mode=%b portb idx=%0d", m, rb), rdb_data_o, ref_rd(m, rb));
        check(tag, $sformatf("mode=%b saved", m), sav_rd_data_o, ref_srd(m));
        @(posedge clk);
        if (we) ref_gpr[$sformatf("%s_%0d", owner(m, wi), wi)] = wd;
        if (swe && sav_owner(m) != "") ref_sav[sav_owner(m)] = swd;
    endtask

    task automatic rd(string tag, logic [4:0] m, int ra, int rb);
        step(tag, m, ra, rb, 1'b0, 0, '0, 1'b0, '0);
    endtask

    task automatic wr(string tag, logic [4:0] m, int wi, logic [DW-1:0] wd);
        step(tag, m, wi, 0, 1'b1, wi, wd, 1'b0, '0);
    endtask

    task automatic swr(string tag, logic [4:0] m, logic [DW-1:0] swd);
        step(tag, m, 0, 1, 1'b0, 0, '0, 1'b1, swd);
    endtask

    logic [4:0] modes [9] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                              5'b10111, 5'b11011, 5'b11111, 5'b00000, 5'b10100};
    logic [4:0] exc [5] = '{5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: everything zero out of reset, in every mode
        for (int i = 0; i < 9; i++) rd("R1", modes[i], 13, 14);
        for (int i = 0; i < 16; i += 2) rd("R1", 5'b10000, i, i + 1);

        // R2: fill user registers and read back
        for (int i = 0; i < 16; i++) wr("R2", 5'b10000, i, 32'h1000_0000 + 32'(i) * 32'h0101);
        for (int i = 0; i < 16; i += 2) rd("R2", 5'b10000, i, i + 1);

        // R3: system mode sees and changes the user set
        for (int i = 0; i < 16; i += 2) rd("R3", 5'b11111, i, i + 1);
        wr("R3", 5'b11111, 5, 32'h5555_AAAA);
        wr("R3", 5'b11111, 13, 32'h1313_0000);
        rd("R3", 5'b10000, 5, 13);

        // R4: fast-interrupt private copies of 8..14
        for (int i = 8; i <= 14; i++) wr("R4", 5'b10001, i, 32'hF100_0000 + 32'(i));
        for (int i = 0; i < 16; i += 2) rd("R4", 5'b10001, i, i + 1);
        for (int i = 8; i < 16; i += 2) rd("R4", 5'b10000, i, i + 1);
        wr("R4", 5'b10001, 3, 32'h0333_0333);
        rd("R4", 5'b10000, 3, 15);

        // R5: two private copies per remaining exception mode
        for (int e = 1; e < 5; e++) begin
            wr("R5", exc[e], 13, 32'hD000_0000 + 32'(e));
            wr("R5", exc[e], 14, 32'hE000_0000 + 32'(e));
        end
        for (int i = 0; i < 9; i++) rd("R5", modes[i], 13, 14);
        rd("R5", 5'b10010, 12, 8);

        // R6: private saved-status per exception mode
        for (int e = 0; e < 5; e++) swr("R6", exc[e], 32'h5A00_0000 + 32'(e) * 32'h11);
        for (int e = 0; e < 5; e++) rd("R6", exc[e], 0, 1);

        // R7: saved-status absent in user and system
        swr("R7", 5'b10000, 32'hDEAD_BEEF);
        swr("R7", 5'b11111, 32'hCAFE_F00D);
        for (int e = 0; e < 5; e++) rd("R7", exc[e], 2, 3);

        // R8: unlisted encodings behave as user
        wr("R8", 5'b00000, 14, 32'h0E0E_0E0E);
        rd("R8", 5'b10000, 14, 13);
        rd("R8", 5'b10100, 13, 9);
        swr("R8", 5'b10100, 32'h1111_2222);
        rd("R8", 5'b10011, 0, 0);

        // R9: collision returns old value, new value next cycle
        step("R9", 5'b10010, 13, 13, 1'b1, 13, 32'h9999_0001, 1'b0, '0);
        rd("R9", 5'b10010, 13, 14);
        step("R9", 5'b10000, 7, 6, 1'b1, 7, 32'h7777_7777, 1'b0, '0);
        rd("R9", 5'b10000, 7, 6);

        // R10: independent ports under random traffic
        for (int n = 0; n < 600; n++) begin
            int ra, rb, wi;
            logic [4:0] m;
            m  = modes[$urandom_range(0, 8)];
            ra = int'($urandom_range(0, 15));
            rb = ($urandom_range(0, 3) == 0) ? ra : int'($urandom_range(0, 15));
            wi = ($urandom_range(0, 2) == 0) ? ra : int'($urandom_range(0, 15));
            step("R10", m, ra, rb, 1'($urandom_range(0, 1)), wi, $urandom(),
                 1'($urandom_range(0, 3) == 0), $urandom());
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule